// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block decides which interrupt the processor takes next. It watches one non-maskable input and a parameterized set of maskable sources, such as external lines and on-chip peripheral requests. Each maskable source has its own enable bit and a one-bit priority level. Two mask bits taken from the processor status word, `mask_i` and `mask_ui`, give three levels of masking when combined with those per-source levels. With both bits clear, every enabled source can be taken. With only `mask_i` set, only level-1 sources can be taken. With both bits set, only the non-maskable input can be taken.

The arbiter is combinational from its inputs to its accept outputs. The only state it keeps is the edge latch on the non-maskable input. On any cycle where `insn_done` is high and some open request exists, the arbiter does four things in that same cycle:
- it raises `accept_vld`,
- it drives the winner's vector number on `accept_vec`,
- it pulses `set_i_pulse`, which tells the processor to set its I bit,
- it clears the non-maskable latch at the next clock edge, if that input won.

Maskable sources are level-sensitive and hold no state inside the block. A request that loses, or that is masked, stays visible for as long as its source keeps it asserted.

Top module: `irq_arbiter_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset when no source is active, `accept_vld` and `set_i_pulse` are 0. The non-maskable latch resets to empty.
- R2: A maskable source whose `src_en` bit is 0 is never accepted, whatever its request, level or the mask bits.
- R3: When both a level-1 source and a level-0 source are open, a level-1 source wins, whatever their indices.
- R4: A pending non-maskable request beats every maskable source. Among open maskable sources of the same level, the lowest index wins.
- R5: A rising edge on `nmi_in`, seen at a clock edge, latches a pending request from the next cycle on. That request is accepted whatever `mask_i` and `mask_ui` are, and is cleared by its acceptance. Holding `nmi_in` high does not raise a second request.
- R6: A level-0 source (`src_lvl` bit 0) is masked whenever `mask_i` is 1, and open when `mask_i` is 0.
- R7: A level-1 source (`src_lvl` bit 1) is masked only when `mask_i` and `mask_ui` are both 1.
- R8: Nothing is accepted on a cycle where `insn_done` is 0. A pending request then waits for the next cycle where `insn_done` is 1.
- R9: `set_i_pulse` is high exactly on the cycles where `accept_vld` is high. In those cycles `accept_vec` is `VEC_BASE` for the non-maskable input and `VEC_BASE+1+i` for maskable source i (defaults 7 and 8+i).
- R10: A request that was masked, or that lost, is accepted at a later `insn_done` cycle once it is open and winning, without being asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge-triggered |
| src_req | input | N_SRC | Level requests of the maskable sources |
| src_en | input | N_SRC | Per-source enable bits |
| src_lvl | input | N_SRC | Per-source priority level (1 = high) |
| mask_i | input | 1 | I mask bit from the status word |
| mask_ui | input | 1 | UI mask bit from the status word |
| insn_done | input | 1 | Instruction-boundary strobe |
| accept_vld | output | 1 | An interrupt is accepted this cycle |
| accept_vec | output | VEC_W | Vector number of the accepted source |
| set_i_pulse | output | 1 | Request to set the I bit, one cycle |

## Verification
The assertions take for granted that `nmi_in` is low while reset is applied. They also assume the mask bits and the source inputs only change between clock edges. The bench therefore drives every input just after the falling edge and keeps `nmi_in` low until reset is released. Random phases choose the mask bits and the `insn_done` strobe freely. The processor's own update of I after an acceptance is deliberately not modelled, so that acceptances in masked states keep being exercised. A reference model in the bench tracks the non-maskable latch using only the edge and acceptance rules.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    GATE_ALL_OPEN = 2'd0,
    GATE_HI_ONLY  = 2'd1,
    GATE_NMI_ONLY = 2'd2
  } gate_e;

  function automatic gate_e gate_of(input logic i_bit, input logic ui_bit);
    if (!i_bit)      return GATE_ALL_OPEN;
    else if (!ui_bit) return GATE_HI_ONLY;
    else             return GATE_NMI_ONLY;
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend,
  output logic rise
);
  logic prev;

  assign rise = nmi_in & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= nmi_in;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  // R5: a pending request survives until it is taken
  p_nmi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take |=> pend);
  // R5: acceptance clears the latch unless a fresh edge arrives
  p_nmi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rise |=> !pend);
  // R5: a level held high gives no new edge
  p_nmi_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_in) && nmi_in |-> !rise);
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  gate_e            gate,
  output logic [N_SRC-1:0] open_hi,
  output logic [N_SRC-1:0] open_lo
);
  logic hi_pass;
  logic lo_pass;

  assign hi_pass = (gate != GATE_NMI_ONLY);
  assign lo_pass = (gate == GATE_ALL_OPEN);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic live;
    assign live       = src_req[g] & src_en[g];
    assign open_hi[g] = live &  src_lvl[g] & hi_pass;
    assign open_lo[g] = live & ~src_lvl[g] & lo_pass;
  end

  always_comb begin
    // R6/R7: a source can never be open at both levels
    a_level_excl_r7: assert ((open_hi & open_lo) == '0);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             nmi_cand,
  input  logic [N_SRC-1:0] open_hi,
  input  logic [N_SRC-1:0] open_lo,
  output logic             win_valid,
  output logic             win_is_nmi,
  output logic [IDX_W-1:0] win_idx,
  output logic [N_SRC-1:0] grant
);
  logic             hi_hit;
  logic             lo_hit;
  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (open_hi[k]) begin
        hi_hit = 1'b1;
        hi_idx = IDX_W'(k);
      end
      if (open_lo[k]) begin
        lo_hit = 1'b1;
        lo_idx = IDX_W'(k);
      end
    end
  end

  always_comb begin
    win_is_nmi = nmi_cand;
    win_valid  = nmi_cand | hi_hit | lo_hit;
    win_idx    = hi_hit ? hi_idx : lo_idx;
    grant      = '0;
    if (!nmi_cand && (hi_hit || lo_hit)) grant[win_idx] = 1'b1;
  end

  always_comb begin
    // R4: at most one maskable grant, none when the non-maskable input wins
    a_grant_onehot_r4: assert ($onehot0(grant));
    a_nmi_excl_r4: assert (!(nmi_cand && (grant != '0)));
  end
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top
  import irq_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 7,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             mask_i,
  input  logic             mask_ui,
  input  logic             insn_done,
  output logic             accept_vld,
  output logic [VEC_W-1:0] accept_vec,
  output logic             set_i_pulse
);
  function automatic logic [VEC_W-1:0] vec_of(input logic is_nmi,
                                               input logic [IDX_W-1:0] idx);
    if (is_nmi) return VEC_W'(VEC_BASE);
    return VEC_W'(VEC_BASE + 1 + int'(idx));
  endfunction

  gate_e            gate;
  logic             nmi_pend;
  logic             nmi_rise;
  logic             nmi_take;
  logic [N_SRC-1:0] open_hi;
  logic [N_SRC-1:0] open_lo;
  logic             win_valid;
  logic             win_is_nmi;
  logic [IDX_W-1:0] win_idx;
  logic [N_SRC-1:0] grant;

  assign gate = gate_of(mask_i, mask_ui);

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (nmi_take),
    .pend   (nmi_pend),
    .rise   (nmi_rise)
  );

  irq_src_gate #(.N_SRC(N_SRC)) u_gate (
    .src_req (src_req),
    .src_en  (src_en),
    .src_lvl (src_lvl),
    .gate    (gate),
    .open_hi (open_hi),
    .open_lo (open_lo)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .nmi_cand   (nmi_pend),
    .open_hi    (open_hi),
    .open_lo    (open_lo),
    .win_valid  (win_valid),
    .win_is_nmi (win_is_nmi),
    .win_idx    (win_idx),
    .grant      (grant)
  );

  assign accept_vld  = rst_n & insn_done & win_valid;
  assign set_i_pulse = accept_vld;
  assign accept_vec  = accept_vld ? vec_of(win_is_nmi, win_idx) : '0;
  assign nmi_take    = accept_vld & win_is_nmi;

  // R2: an accepted maskable source was enabled and requesting
  p_enabled_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld && !win_is_nmi |-> src_en[win_idx] && src_req[win_idx]);
  // R6: with I set, a maskable winner must be level 1
  p_lo_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld && !win_is_nmi && mask_i |-> src_lvl[win_idx]);
  // R7: with I and UI both set, only the non-maskable input gets in
  p_hi_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld && mask_i && mask_ui |-> win_is_nmi);
  // R4/R5: a pending non-maskable request at a boundary is always taken
  p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && insn_done |-> accept_vld && accept_vec == VEC_W'(VEC_BASE));
  // R8: no acceptance away from an instruction boundary
  p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld |-> insn_done);
  // R3: a level-1 grant whenever any level-1 source is open and NMI idle
  p_hi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_pend && (open_hi != '0) |-> (grant & open_hi) != '0);
  // R9: the set-I request coincides with acceptance
  p_seti_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i_pulse == accept_vld);
endmodule

// File: tb/tb_irq_arbiter_top.sv
module tb_irq_arbiter_top;
  localparam int N = 8;
  localparam int VB = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         nmi_in;
  logic [N-1:0] src_req, src_en, src_lvl;
  logic         mask_i, mask_ui, insn_done;
  logic         accept_vld, set_i_pulse;
  logic [7:0]   accept_vec;

  int total = 0;
  int bad   = 0;
  bit m_prev = 0;
  bit m_pend = 0;

  always #10 clk = ~clk;

  irq_arbiter_top #(.N_SRC(N), .VEC_W(8), .VEC_BASE(VB)) dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .src_req(src_req),
    .src_en(src_en), .src_lvl(src_lvl), .mask_i(mask_i), .mask_ui(mask_ui),
    .insn_done(insn_done), .accept_vld(accept_vld), .accept_vec(accept_vec),
    .set_i_pulse(set_i_pulse)
  );

  // expected vector, -1 when nothing is taken
  function automatic int expect_vec();
    if (!insn_done) return -1;
    if (m_pend) return VB;
    if (!(mask_i && mask_ui))
      for (int s = 0; s < N; s++)
        if (src_req[s] && src_en[s] && src_lvl[s]) return VB + 1 + s;
    if (!mask_i)
      for (int s = 0; s < N; s++)
        if (src_req[s] && src_en[s] && !src_lvl[s]) return VB + 1 + s;
    return -1;
  endfunction

  task automatic check(input string tag);
    int e;
    bit ok;
    e = expect_vec();
    if (e < 0) ok = !accept_vld && !set_i_pulse;
    else       ok = accept_vld && set_i_pulse && (int'(accept_vec) == e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: vld=%0b seti=%0b vec=%0d expected vec=%0d", tag,
               accept_vld, set_i_pulse, accept_vec, e);
    end
  endtask

  // drive after negedge, check, then advance the model over the next edge
  task automatic step(input bit nmi, input logic [N-1:0] rq, input logic [N-1:0] en,
                      input logic [N-1:0] lv, input bit mi, input bit mu,
                      input bit dn, input string tag);
    int e;
    nmi_in = nmi; src_req = rq; src_en = en; src_lvl = lv;
    mask_i = mi; mask_ui = mu; insn_done = dn;
    #2;
    check(tag);
    e = expect_vec();
    @(posedge clk);
    if (nmi && !m_prev) m_pend = 1;
    else if (e == VB)   m_pend = 0;
    m_prev = nmi;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    string tg;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 0; nmi_in = 0; src_req = '0; src_en = '0; src_lvl = '0;
    mask_i = 0; mask_ui = 0; insn_done = 1;
    repeat (3) @(negedge clk);
    #2;
    total++;
    if (accept_vld || set_i_pulse) begin
      bad++;
      $display("FAIL R1: vld=%0b seti=%0b expected 0 0", accept_vld, set_i_pulse);
    end
    @(negedge clk);
    rst_n = 1;
    step(0, '0, '0, '0, 0, 0, 1, "R1");
    // R2 disabled source
    step(0, 8'h08, 8'h00, 8'h08, 0, 0, 1, "R2");
    // R3 level 1 beats lower-index level 0
    step(0, 8'h22, 8'hFF, 8'h20, 0, 0, 1, "R3");
    // R4 lowest index among level 0
    step(0, 8'h44, 8'hFF, 8'h00, 0, 0, 1, "R4");
    // R5 NMI edge while fully masked, with a level-1 source present
    step(1, 8'h10, 8'hFF, 8'h10, 1, 1, 1, "R5");
    step(1, 8'h10, 8'hFF, 8'h10, 1, 1, 1, "R5");
    step(1, 8'h10, 8'hFF, 8'h10, 1, 1, 1, "R5");
    // R8 NMI edge waits for the boundary
    step(0, '0, '0, '0, 0, 0, 0, "R8");
    step(1, '0, '0, '0, 0, 0, 0, "R8");
    step(1, 8'h01, 8'hFF, 8'h00, 0, 0, 0, "R8");
    step(1, 8'h01, 8'hFF, 8'h00, 0, 0, 1, "R4");
    step(1, 8'h01, 8'hFF, 8'h00, 0, 0, 1, "R4");
    // R6 level 0 masked by I, level 1 open
    step(0, 8'h01, 8'hFF, 8'h00, 1, 0, 1, "R6");
    step(0, 8'h11, 8'hFF, 8'h10, 1, 0, 1, "R6");
    // R7 level 1 masked only with both bits
    step(0, 8'h10, 8'hFF, 8'h10, 1, 1, 1, "R7");
    step(0, 8'h10, 8'hFF, 8'h10, 0, 1, 1, "R7");
    // R10 masked request taken after unmask without re-assertion
    step(0, 8'h80, 8'hFF, 8'h00, 1, 0, 1, "R10");
    step(0, 8'h80, 8'hFF, 8'h00, 1, 1, 1, "R10");
    step(0, 8'h80, 8'hFF, 8'h00, 0, 0, 1, "R10");
    // R9 vector of the top source
    step(0, 8'h80, 8'hFF, 8'h80, 0, 0, 1, "R9");
    for (int n = 0; n < 4000; n++) begin
      bit nmi;
      nmi = ($urandom % 16) == 0 ? ~m_prev : m_prev;
      tg = m_pend ? "R5" : "R4";
      step(nmi, N'($urandom), N'($urandom), N'($urandom),
           1'($urandom), 1'($urandom), ($urandom % 4) != 0, tg);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule